// File: doc/BRIEF.md
# Scanned Keyboard Matrix Emulator

This block stands in for a physical key matrix that a host scans. The host drives eleven strobe lines. The block answers on seven sense lines, and each sense line shows whether any key in its row is pressed under a currently strobed column. Key events come in as bytes from a host-side source and wait in a sixteen-entry queue. The queue is drained at a slow, fixed pace: one event per tick, where a tick is a parameterised number of clock cycles (32 ticks per second in the intended clock setup).

When an event leaves the queue, its low seven bits go out on a lookup address. An external translation table answers in the same cycle with a matrix code (row in the upper nibble, column in the lower nibble) and a valid flag. A press sets the addressed matrix bit and a release clears it. An eighth row, one past the last sense row, does not touch the matrix at all. Instead it drives five discrete special-button outputs.

A restore input releases every key at once and empties the queue.

Top module: `kmx_top`

## Requirements
- R1: After reset, senseOut, specialOut and overflow are all zero.
- R2: senseOut[i] is high exactly when row i's pressed-key mask ANDed with strobeIn is nonzero. It follows strobe changes combinationally, in the same cycle.
- R3: For a dequeued event, mapAddr carries the event byte's bits [6:0]. The returned mapCode gives the row in bits [7:4] and the column in bits [3:0]. An event byte with bit 7 clear is a press, and a press sets that matrix bit.
- R4: An event byte with bit 7 set is a release, and a release clears the addressed matrix bit.
- R5: A code whose row equals 7 drives specialOut[column], for columns 0 to 4. The output goes high on press and low on release, and the sense lines are unaffected.
- R6: An event is dropped with no effect when mapValid is low, when the row exceeds 7, or when the column is out of range (11 or more for rows 0 to 6, 5 or more for row 7).
- R7: At most one event is applied per tick, ticks come every TICK_DIV clocks, and events are applied in arrival order.
- R8: The queue holds 16 events. An evtValid write while 16 are held is discarded and sets overflow, which stays set until reset.
- R9: A clearAll cycle clears every matrix bit (senseOut is zero from the next cycle), empties the queue and discards a write made in the same cycle. specialOut and overflow are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| strobeIn | input | 11 | Column strobe vector from the scanning host |
| evtValid | input | 1 | Write one event byte into the queue |
| evtData | input | 8 | Event byte: bit 7 release flag, bits [6:0] key number |
| clearAll | input | 1 | Restore: release all keys and empty the queue |
| mapAddr | output | 7 | Lookup address of the event at the queue head |
| mapCode | input | 8 | Lookup result: row [7:4], column [3:0] |
| mapValid | input | 1 | Lookup result is a real key |
| senseOut | output | 7 | Row sense lines |
| specialOut | output | 5 | Special-button outputs |
| overflow | output | 1 | Sticky queue-overflow flag |

## Verification
The assertions take for granted that the lookup answers combinationally from mapAddr within the same cycle. The pacing property also assumes that TICK_DIV is at least 2, so that two dequeues can never sit on adjacent clocks. The bench meets these conditions with a purely combinational lookup model, a short tick divider of 8 and inputs driven only on falling edges. It waits at least one full tick interval per queued event before sampling the matrix.

// File: rtl/kmx_pkg.sv
package kmx_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic push;   // store evtData at the write pointer
    logic pop;    // apply the head event this cycle
    logic clear;  // release all keys
  } kmxStrb_t;
endpackage

// File: rtl/kmx_ctrl.sv
module kmx_ctrl
  import kmx_pkg::*;
#(
  parameter int QDEPTH   = 16,
  parameter int TICK_DIV = 1562500,
  localparam int PW = $clog2(QDEPTH),
  localparam int CW = $clog2(QDEPTH + 1),
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          evtValid,
  input  logic          clearAll,
  output kmxStrb_t      strb,
  output logic [PW-1:0] wrPtr,
  output logic [PW-1:0] rdPtr,
  output logic [CW-1:0] qCount,
  output logic          overflow
);
  logic [DW-1:0] divCnt;
  logic          tick;
  logic          qFull;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(QDEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign tick  = (divCnt == DW'(TICK_DIV - 1));
  assign qFull = (qCount == CW'(QDEPTH));

  always_comb begin
    strb.clear = clearAll;
    strb.push  = evtValid & ~qFull & ~clearAll;
    strb.pop   = tick & (qCount != '0) & ~clearAll;
  end

  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else if (tick) divCnt <= '0;
    else divCnt <= divCnt + DW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN || clearAll) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      qCount <= '0;
    end else begin
      if (strb.push) wrPtr <= nextPtr(wrPtr);
      if (strb.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strb.push, strb.pop})
        2'b10:   qCount <= qCount + CW'(1);
        2'b01:   qCount <= qCount - CW'(1);
        default: qCount <= qCount;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) overflow <= 1'b0;
    else if (evtValid && qFull && !clearAll) overflow <= 1'b1;
  end
endmodule

// File: rtl/kmx_datapath.sv
module kmx_datapath
  import kmx_pkg::*;
#(
  parameter int QDEPTH      = 16,
  parameter int NUM_STROBE  = 11,
  parameter int NUM_SENSE   = 7,
  parameter int NUM_SPECIAL = 5,
  localparam int PW = $clog2(QDEPTH)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  kmxStrb_t               strb,
  input  logic [PW-1:0]          wrPtr,
  input  logic [PW-1:0]          rdPtr,
  input  logic [7:0]             evtData,
  input  logic [NUM_STROBE-1:0]  strobeIn,
  input  logic [7:0]             mapCode,
  input  logic                   mapValid,
  output logic [6:0]             mapAddr,
  output logic [NUM_SENSE-1:0]   senseOut,
  output logic [NUM_SPECIAL-1:0] specialOut
);
  logic [7:0]            qMem [QDEPTH];
  logic [7:0]            headByte;
  logic                  isRelease;
  logic [3:0]            codeRow;
  logic [3:0]            codeCol;
  logic                  keyHit;
  logic                  spHit;
  logic [NUM_STROBE-1:0] colOneHot;
  logic [NUM_STROBE-1:0] rowMask [NUM_SENSE];

  always_ff @(posedge clk) begin
    if (strb.push) qMem[wrPtr] <= evtData;
  end

  assign headByte  = qMem[rdPtr];
  assign mapAddr   = headByte[6:0];
  assign isRelease = headByte[7];
  assign codeRow   = mapCode[7:4];
  assign codeCol   = mapCode[3:0];

  assign keyHit = strb.pop & mapValid & (codeRow < 4'(NUM_SENSE))
                  & (codeCol < 4'(NUM_STROBE));
  assign spHit  = strb.pop & mapValid & (codeRow == 4'(NUM_SENSE))
                  & (codeCol < 4'(NUM_SPECIAL));
  assign colOneHot = NUM_STROBE'(1) << codeCol;

  for (genvar r = 0; r < NUM_SENSE; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rstN || strb.clear) rowMask[r] <= '0;
      else if (keyHit && codeRow == 4'(r))
        rowMask[r] <= isRelease ? (rowMask[r] & ~colOneHot)
                                : (rowMask[r] | colOneHot);
    end
    assign senseOut[r] = |(rowMask[r] & strobeIn);
  end

  for (genvar s = 0; s < NUM_SPECIAL; s++) begin : g_special
    always_ff @(posedge clk) begin
      if (!rstN) specialOut[s] <= 1'b0;
      else if (spHit && codeCol == 4'(s)) specialOut[s] <= ~isRelease;
    end
  end
endmodule

// File: rtl/kmx_top.sv
module kmx_top
  import kmx_pkg::*;
#(
  parameter int QDEPTH      = 16,
  parameter int TICK_DIV    = 1562500,
  parameter int NUM_STROBE  = 11,
  parameter int NUM_SENSE   = 7,
  parameter int NUM_SPECIAL = 5,
  localparam int PW = $clog2(QDEPTH),
  localparam int CW = $clog2(QDEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_STROBE-1:0]  strobeIn,
  input  logic                   evtValid,
  input  logic [7:0]             evtData,
  input  logic                   clearAll,
  output logic [6:0]             mapAddr,
  input  logic [7:0]             mapCode,
  input  logic                   mapValid,
  output logic [NUM_SENSE-1:0]   senseOut,
  output logic [NUM_SPECIAL-1:0] specialOut,
  output logic                   overflow
);
  kmxStrb_t      ctlStrb;
  logic [PW-1:0] wrPtr;
  logic [PW-1:0] rdPtr;
  logic [CW-1:0] qCount;

  kmx_ctrl #(.QDEPTH(QDEPTH), .TICK_DIV(TICK_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .clearAll(clearAll),
    .strb(ctlStrb), .wrPtr(wrPtr), .rdPtr(rdPtr), .qCount(qCount),
    .overflow(overflow)
  );

  kmx_datapath #(
    .QDEPTH(QDEPTH), .NUM_STROBE(NUM_STROBE),
    .NUM_SENSE(NUM_SENSE), .NUM_SPECIAL(NUM_SPECIAL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(ctlStrb), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .evtData(evtData), .strobeIn(strobeIn), .mapCode(mapCode),
    .mapValid(mapValid), .mapAddr(mapAddr), .senseOut(senseOut),
    .specialOut(specialOut)
  );
endmodule

// File: rtl/kmx_checker.sv
module kmx_checker #(
  parameter int QDEPTH      = 16,
  parameter int NUM_STROBE  = 11,
  parameter int NUM_SENSE   = 7,
  parameter int NUM_SPECIAL = 5,
  localparam int CW = $clog2(QDEPTH + 1)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   clearAll,
  input logic [NUM_STROBE-1:0]  strobeIn,
  input logic [NUM_SENSE-1:0]   senseOut,
  input logic [NUM_SPECIAL-1:0] specialOut,
  input logic                   overflow,
  input logic [CW-1:0]          qCount,
  input logic                   popEvt
);
  assert_dark_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobeIn == '0) |-> (senseOut == '0));

  assert_restore_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    clearAll |=> (senseOut == '0));

  assert_restore_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    clearAll |=> (qCount == '0));

  assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= CW'(QDEPTH));

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  assert_single_pop_R7: assert property (@(posedge clk) disable iff (!rstN)
    popEvt |=> !popEvt);

  assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rstN)
    popEvt |-> (qCount != '0));

  assert_special_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !popEvt |=> $stable(specialOut));
endmodule

bind kmx_top kmx_checker #(
  .QDEPTH(QDEPTH), .NUM_STROBE(NUM_STROBE),
  .NUM_SENSE(NUM_SENSE), .NUM_SPECIAL(NUM_SPECIAL)
) u_chk (
  .clk(clk), .rstN(rstN), .clearAll(clearAll), .strobeIn(strobeIn),
  .senseOut(senseOut), .specialOut(specialOut), .overflow(overflow),
  .qCount(qCount), .popEvt(ctlStrb.pop)
);

// File: tb/kmx_top_tb.sv
module kmx_top_tb;
  localparam int TICK = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [10:0] strobeIn = '1;
  logic        evtValid = 1'b0;
  logic [7:0]  evtData = '0;
  logic        clearAll = 1'b0;
  logic [6:0]  mapAddr;
  logic [7:0]  mapCode;
  logic        mapValid;
  logic [6:0]  senseOut;
  logic [4:0]  specialOut;
  logic        overflow;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  // Lookup model: code equals key number; key 0x11 is unmapped
  always_comb begin
    mapCode  = {1'b0, mapAddr};
    mapValid = (mapAddr != 7'h11);
  end

  kmx_top #(.TICK_DIV(TICK)) u_dut (
    .clk(clk), .rstN(rstN), .strobeIn(strobeIn), .evtValid(evtValid),
    .evtData(evtData), .clearAll(clearAll), .mapAddr(mapAddr),
    .mapCode(mapCode), .mapValid(mapValid), .senseOut(senseOut),
    .specialOut(specialOut), .overflow(overflow)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    evtValid = 1'b1;
    evtData  = b;
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  task automatic drain(input int n);
    repeat ((n + 1) * TICK + 4) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 sense", senseOut, 0);
    chk("R1 special", specialOut, 0);
    chk("R1 overflow", overflow, 0);
  endtask

  task automatic t_press_strobe;
    push(8'h25);                   // row 2, col 5
    drain(1);
    chk("R3 press row2", senseOut, 7'h04);
    strobeIn = 11'h020;
    @(negedge clk);
    chk("R2 matching strobe", senseOut, 7'h04);
    strobeIn = 11'h7DF;
    @(negedge clk);
    chk("R2 other strobes", senseOut, 7'h00);
    strobeIn = '1;
  endtask

  task automatic t_release;
    push(8'hA5);
    drain(1);
    chk("R4 release", senseOut, 0);
  endtask

  task automatic t_special;
    push(8'h73);                   // row 7, col 3
    drain(1);
    chk("R5 special press", specialOut, 5'h08);
    chk("R5 sense untouched", senseOut, 0);
    push(8'hF3);
    drain(1);
    chk("R5 special release", specialOut, 0);
    push(8'h71);                   // left high for restore test
    drain(1);
    chk("R5 special 1", specialOut, 5'h02);
  endtask

  task automatic t_dropped;
    push(8'h11);                   // unmapped key
    push(8'h1C);                   // column 12
    push(8'h76);                   // special column 6
    drain(3);
    chk("R6 dropped sense", senseOut, 0);
    chk("R6 dropped special", specialOut, 5'h02);
  endtask

  task automatic t_pacing;
    int guard;
    push(8'h30);
    push(8'h40);
    guard = 0;
    while (senseOut == 0 && guard < 4 * TICK) begin
      @(negedge clk);
      guard++;
    end
    chk("R7 first only", senseOut, 7'h08);
    drain(1);
    chk("R7 both applied", senseOut, 7'h18);
    push(8'hB0);
    push(8'hC0);
    push(8'h50);
    push(8'hD0);                   // order matters: row 5 ends released
    drain(4);
    chk("R7 order", senseOut, 0);
  endtask

  task automatic t_overflow;
    chk("R8 no overflow yet", overflow, 0);
    @(negedge clk);
    for (int i = 0; i < 24; i++) begin
      evtValid = 1'b1;
      evtData  = 8'h7F;            // harmless: dropped on apply
      @(negedge clk);
    end
    evtValid = 1'b0;
    chk("R8 overflow set", overflow, 1);
    drain(16);
    chk("R8 overflow sticky", overflow, 1);
  endtask

  task automatic t_restore;
    push(8'h00);
    push(8'h61);
    drain(2);
    chk("R9 keys down", senseOut, 7'h41);
    push(8'h22);
    push(8'h33);
    @(negedge clk);
    clearAll = 1'b1;
    evtValid = 1'b1;
    evtData  = 8'h44;
    @(negedge clk);
    clearAll = 1'b0;
    evtValid = 1'b0;
    chk("R9 released", senseOut, 0);
    drain(3);
    chk("R9 queue empty", senseOut, 0);
    chk("R9 special kept", specialOut, 5'h02);
    chk("R9 overflow kept", overflow, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_press_strobe();
    t_release();
    t_special();
    t_dropped();
    t_pacing();
    t_overflow();
    t_restore();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule